// File: doc/BRIEF.md
# Fractional-Frequency PWM Generator

A single-channel pulse-width modulated output whose rate is set by a 16-bit phase accumulator. Every clock the accumulator advances by a programmable increment, so the output period is 65536 divided by that increment, in clocks. A wrap of the accumulator closes one output period and opens the next. With a 25 MHz reference clock an increment of 1 gives about 381 Hz. The largest legal increment, 0x8002, gives just over half the clock rate.

The high time comes from an 8-bit threshold compared against the upper byte of the accumulator. The output is high while that byte is at or above the threshold, so a larger threshold gives a shorter pulse. A duty fraction d corresponds roughly to a threshold of 255 − 255·d. Software controls everything through one 32-bit control word and can read it back. New increment and threshold values sit in a shadow copy. They reach the running generator only when software requests an update, and then only at the next period boundary. This keeps a reprogrammed waveform free of short or torn periods.

Top module: `pwm_frac_gen`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0 and `pwm_out` is low.
- R2: Control word layout: bit 31 = enable, bit 30 = update request, bits 23:8 = increment, bits 7:0 = threshold. `rd_data` returns the last accepted enable, increment and threshold, together with the live update-request flag. It is valid from the second rising edge after the write edge. Bits 29:24 always read 0, even when written with ones.
- R3: While enable is 0, `pwm_out` is low and the phase is held at 0. After a write that sets enable on edge k, with increment I and threshold T active, `pwm_out` first goes high on edge k+1+ceil(T·256/I). For I=0x100 and T=0x80 it stays low through the 128 sampling points after the write, then goes high.
- R4: While enabled, the output period is 65536/I clocks. For I=0x400, exactly 10 rising edges of `pwm_out` fall in any 640-cycle window.
- R5: `pwm_out` is high while phase[15:8] >= threshold. For I=0x100 this gives 256 − T high cycles in each 256-cycle window.
- R6: While enabled, a write with bit 30 set does not change the running waveform until the next accumulator wrap. On that wrap the shadow values become active and bit 30 reads 0 again. Until then bit 30 reads 1.
- R7: A write with bit 30 clear updates the read-back fields but not the running increment or threshold.
- R8: While disabled, a pending update becomes active on the next clock edge, so bit 30 reads 0 two edges after the write.
- R9: A write whose increment field exceeds 0x8002 is ignored entirely, including its enable and update bits. 0x8002 itself is accepted.
- R10: A pending update is not cancelled by a later write with bit 30 clear. The pending copy uses the newest shadow values at the wrap.
- R11: Turning enable off and on with bit 30 clear keeps the active increment and threshold. After re-enabling, the waveform has the same duty as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Registered read-back of the control word |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a write that lands while an update is already pending. The update must stay pending, and the wrap must pick up the newest shadow values. The stimulus first waits for an update to retire by polling bit 30. It then issues the update write and a follow-up write with bit 30 clear within a few cycles, so both land well before the next wrap. The check then observes the flag and the resulting duty. A cycle-level scoreboard also compares every output cycle against a model derived from the requirements. This catches a change that reaches the waveform before its boundary.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int REG_W          = 32;
  localparam int EN_BIT         = 31;
  localparam int UPD_BIT        = 30;
  localparam int BASE_LSB       = 8;
  localparam int DIV_LSB        = 0;
  localparam int DEF_ACC_W      = 16;
  localparam int DEF_DIV_W      = 8;
  localparam int unsigned DEF_BASE_LIMIT = 32'h0000_8002;
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_frac_pkg::*;
#(
  parameter int          ACC_W      = DEF_ACC_W,
  parameter int          DIV_W      = DEF_DIV_W,
  parameter int unsigned BASE_LIMIT = DEF_BASE_LIMIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cyc_wrap,
  output logic             run_en,
  output logic             upd_pend,
  output logic [ACC_W-1:0] act_base,
  output logic [DIV_W-1:0] act_div,
  output logic [REG_W-1:0] rd_data
);
  localparam int               BASE_MSB = BASE_LSB + ACC_W - 1;
  localparam int               DIV_MSB  = DIV_LSB + DIV_W - 1;
  localparam logic [ACC_W-1:0] LIMIT    = ACC_W'(BASE_LIMIT);

  logic [ACC_W-1:0] sh_base;
  logic [DIV_W-1:0] sh_div;
  logic [ACC_W-1:0] wr_base;
  logic             wr_ok;
  logic             load;
  logic [REG_W-1:0] rd_n;

  assign wr_base = wr_data[BASE_MSB:BASE_LSB];
  assign wr_ok   = wr_en && (wr_base <= LIMIT);
  // shadow moves to active at a period boundary, or at once when stopped
  assign load    = upd_pend && (cyc_wrap || !run_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en   <= 1'b0;
      upd_pend <= 1'b0;
      sh_base  <= '0;
      sh_div   <= '0;
      act_base <= '0;
      act_div  <= '0;
    end else begin
      if (load) begin
        act_base <= sh_base;
        act_div  <= sh_div;
      end
      upd_pend <= (upd_pend && !load) || (wr_ok && wr_data[UPD_BIT]);
      if (wr_ok) begin
        run_en  <= wr_data[EN_BIT];
        sh_base <= wr_base;
        sh_div  <= wr_data[DIV_MSB:DIV_LSB];
      end
    end
  end

  always_comb begin
    rd_n                    = '0;
    rd_n[EN_BIT]            = run_en;
    rd_n[UPD_BIT]           = upd_pend;
    rd_n[BASE_MSB:BASE_LSB] = sh_base;
    rd_n[DIV_MSB:DIV_LSB]   = sh_div;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase,
  output logic             cyc_wrap
);
  logic [ACC_W:0] sum;

  assign sum      = {1'b0, phase} + {1'b0, step};
  assign cyc_wrap = run_en && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || !run_en) phase <= '0;
    else                phase <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] phase_hi,
  input  logic [DIV_W-1:0] thresh,
  output logic             pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run_en && (phase_hi >= thresh);
  end
endmodule

// File: rtl/pwm_frac_gen.sv
module pwm_frac_gen
  import pwm_frac_pkg::*;
#(
  parameter int          ACC_W      = DEF_ACC_W,
  parameter int          DIV_W      = DEF_DIV_W,
  parameter int unsigned BASE_LIMIT = DEF_BASE_LIMIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pwm_out
);
  logic             en_w;
  logic             upd_w;
  logic             wrap_w;
  logic [ACC_W-1:0] act_base_w;
  logic [DIV_W-1:0] act_div_w;
  logic [ACC_W-1:0] phase_w;

  pwm_ctrl_regs #(.ACC_W(ACC_W), .DIV_W(DIV_W), .BASE_LIMIT(BASE_LIMIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cyc_wrap(wrap_w), .run_en(en_w), .upd_pend(upd_w),
    .act_base(act_base_w), .act_div(act_div_w), .rd_data(rd_data)
  );

  pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .run_en(en_w), .step(act_base_w),
    .phase(phase_w), .cyc_wrap(wrap_w)
  );

  pwm_duty_cmp #(.DIV_W(DIV_W)) u_cmp (
    .clk(clk), .rst(rst), .run_en(en_w),
    .phase_hi(phase_w[ACC_W-1 -: DIV_W]), .thresh(act_div_w), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_frac_gen_chk.sv
module pwm_frac_gen_chk #(
  parameter int          ACC_W      = 16,
  parameter int          DIV_W      = 8,
  parameter int unsigned BASE_LIMIT = 32'h8002
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             upd,
  input logic             wrap,
  input logic [ACC_W-1:0] phase,
  input logic [ACC_W-1:0] act_base,
  input logic [DIV_W-1:0] act_div,
  input logic [31:0]      rd_data,
  input logic             pwm_out
);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(BASE_LIMIT);

  assert_off_low_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);
  assert_phase_held_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == '0));
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[29:24] == 6'b0);
  assert_active_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> ($stable(act_div) && $stable(act_base)));
  assert_pending_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (upd && en && !wrap) |=> upd);
  assert_base_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    act_base <= LIMIT);
endmodule

bind pwm_frac_gen pwm_frac_gen_chk #(.ACC_W(ACC_W), .DIV_W(DIV_W), .BASE_LIMIT(BASE_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .upd(upd_w), .wrap(wrap_w), .phase(phase_w),
  .act_base(act_base_w), .act_div(act_div_w), .rd_data(rd_data), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_frac_gen.sv
module tb_pwm_frac_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pwm_frac_gen dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                    .rd_data(rd_data), .pwm_out(pwm_out));

  // scoreboard model built from the requirements
  typedef struct packed { logic p; logic [31:0] r; } exp_t;
  exp_t q[$];
  logic        m_en, m_upd;
  logic [15:0] m_sb, m_ab, m_acc;
  logic [7:0]  m_sd, m_ad;

  always @(posedge clk) begin
    logic [16:0] sum;
    logic wrap, load, ok, np;
    logic [31:0] nr;
    logic [15:0] nacc;
    if (rst) begin
      m_en = 0; m_upd = 0; m_sb = 0; m_ab = 0; m_acc = 0; m_sd = 0; m_ad = 0;
      q.push_back('{p: 1'b0, r: 32'h0});
    end else begin
      sum  = {1'b0, m_acc} + {1'b0, m_ab};
      wrap = m_en && sum[16];
      load = m_upd && (wrap || !m_en);
      ok   = wr_en && (wr_data[23:8] <= 16'h8002);
      np   = m_en && (m_acc[15:8] >= m_ad);
      nr   = {m_en, m_upd, 6'b0, m_sb, m_sd};
      nacc = m_en ? sum[15:0] : 16'h0;
      if (load) begin m_ab = m_sb; m_ad = m_sd; end
      m_upd = (m_upd && !load) || (ok && wr_data[30]);
      if (ok) begin m_en = wr_data[31]; m_sb = wr_data[23:8]; m_sd = wr_data[7:0]; end
      m_acc = nacc;
      q.push_back('{p: np, r: nr});
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks += 2;
      if (pwm_out !== e.p) begin
        errors++;
        $display("FAIL R5 scoreboard pwm_out actual=%b expected=%b t=%0t", pwm_out, e.p, $time);
      end
      if (rd_data !== e.r) begin
        errors++;
        $display("FAIL R2 scoreboard rd_data actual=%h expected=%h t=%0t", rd_data, e.r, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (pwm_out) c++; end
  endtask

  task automatic count_rise(input int n, output int c);
    logic prev;
    c = 0; prev = pwm_out;
    repeat (n) begin @(negedge clk); if (pwm_out && !prev) c++; prev = pwm_out; end
  endtask

  task automatic wait_upd(input int lim, output int n);
    n = 0;
    do begin idle(1); n++; end while (rd_data[30] && n < lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, n;
    idle(4); rst = 1'b0; idle(1);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    chk("R1 pwm_out after reset", {31'b0, pwm_out}, 32'h0);

    wr(32'h3F01_0080); idle(1);
    chk("R2 readback, reserved bits zero", rd_data, 32'h0001_0080);

    wr(32'h4001_0080); idle(2);
    chk("R8 update applied while disabled", rd_data, 32'h0001_0080);
    idle(5);
    chk("R3 output low while disabled", {31'b0, pwm_out}, 32'h0);

    wr(32'h8001_0080);
    count_high(128, c);
    chk("R3 low from phase 0 after enable", c, 0);
    idle(1);
    chk("R3 first high after fresh start", {31'b0, pwm_out}, 32'h1);
    count_high(256, c);
    chk("R5 high count T=0x80 I=0x100", c, 128);

    wr(32'hC004_0080);
    wait_upd(300, n);
    chk("R6 update retired within one period", {31'b0, (n <= 259) && !rd_data[30]}, 32'h1);
    count_rise(640, c);
    chk("R4 rising edges I=0x400", c, 10);
    count_high(640, c);
    chk("R5 high count I=0x400", c, 320);

    wr(32'hC001_0040); idle(1);
    chk("R6 flag reads 1 while pending", {31'b0, rd_data[30]}, 32'h1);
    wait_upd(300, n);
    chk("R6 update retired at next wrap", {31'b0, (n <= 67) && !rd_data[30]}, 32'h1);
    count_high(256, c);
    chk("R6 new threshold active", c, 192);

    wr(32'hC001_0020); wr(32'h8001_0020); idle(1);
    chk("R10 pending survives plain write", {31'b0, rd_data[30]}, 32'h1);
    wait_upd(300, n);
    count_high(256, c);
    chk("R10 pending update applied", c, 224);

    wr(32'h8001_0010); idle(1);
    chk("R7 readback shows shadow", rd_data, 32'h8001_0010);
    count_high(256, c);
    chk("R7 running threshold unchanged", c, 224);

    wr(32'hC080_0355); idle(2);
    chk("R9 out-of-range write ignored", rd_data, 32'h8001_0010);
    wr(32'h0080_0255); idle(2);
    chk("R9 limit value accepted", rd_data, 32'h0080_0255);
    chk("R3 low after disable", {31'b0, pwm_out}, 32'h0);

    wr(32'h8080_0255); idle(1);
    chk("R11 fields kept on enable", rd_data, 32'h8080_0255);
    idle(4);
    count_high(256, c);
    chk("R11 active settings kept across toggle", c, 224);

    wr(32'h4080_0255); wr(32'h8080_0255);
    idle(200);
    wr(32'h0000_0000); idle(4);
    chk("R3 low after final disable", {31'b0, pwm_out}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule